// File: doc/BRIEF.md
# Colour-Tagged Decode Filter

This block sits in the decode stage of a prefetching pipeline. Each fetched item carries an address, an instruction word, a one-bit colour and a flag that says whether the instruction is a jump. The filter keeps a one-bit colour of its own and compares every incoming item against it. Items whose colour differs from the stage colour belong to a path that has since been abandoned, so they are dropped without any output.

When an item's colour matches and it is a jump, the filter issues a redirect request back to the fetch side. The request carries the jump target, taken from a fixed field of the instruction word, and the inverted stage colour. The stage colour flips in the cycle in which the redirect handshake completes, so any item prefetched along the old path is then rejected. A matching item that is not a jump goes to the execute interface unchanged.

All three interfaces use valid/ready handshakes. Both outputs are registered. Input is stalled while a redirect is outstanding, and while an execute item is waiting and the consumer is not ready.

Top module: `colour_decode_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, `rd_valid` and `ex_valid` are 0 and `in_ready` is 1; the stage colour starts at 0.
- R2: A matching jump accepted at a clock edge makes `rd_valid` 1 after that edge. `rd_target` equals `in_instr[TGT_LSB +: ADDR_W]` and `rd_colour` is the inverse of the stage colour. `rd_target` and `rd_colour` hold while `rd_ready` is 0.
- R3: The stage colour flips at the edge where `rd_valid` and `rd_ready` are both 1. Later items are judged against the new colour, so successive redirects alternate in colour.
- R4: A matching item whose jump flag is 0 makes `ex_valid` 1 after the accepting edge, with `ex_addr` and `ex_instr` equal to the item's address and instruction. Only one of `rd_valid` and `ex_valid` is 1 at any time.
- R5: An accepted item whose colour differs from the stage colour produces no redirect and no execute output, and it leaves the stage colour unchanged.
- R6: `in_ready` is 0 whenever `rd_valid` is 1, so no item is taken until the redirect transfer has finished.
- R7: While `ex_valid` is 1 and `ex_ready` is 0, `in_ready` is 0 and `ex_addr` and `ex_instr` stay stable.
- R8: When `ex_valid` and `ex_ready` are both 1, `in_ready` is 1. A stream of matching non-jump items is then accepted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetched item offered |
| in_ready | output | 1 | Filter can take an item this cycle |
| in_addr | input | ADDR_W | Item address |
| in_instr | input | INSTR_W | Instruction word |
| in_colour | input | 1 | Path colour of the item |
| in_is_jump | input | 1 | 1 when the instruction is a jump |
| rd_valid | output | 1 | Redirect request pending |
| rd_ready | input | 1 | Fetch side takes the redirect |
| rd_target | output | ADDR_W | Jump target |
| rd_colour | output | 1 | Colour of the new path |
| ex_valid | output | 1 | Execute item pending |
| ex_ready | input | 1 | Execute side takes the item |
| ex_addr | output | ADDR_W | Address of the item to execute |
| ex_instr | output | INSTR_W | Instruction to execute |

## Verification
Every result is due one clock edge after the item's input handshake. An item accepted at edge k shows on `rd_valid` or `ex_valid` after edge k, and the colour flip comes at the edge of the redirect handshake. The driver pushes the expected redirect or execute item into a queue at the falling edge before the accepting edge. The monitor pops an entry at each falling edge where an output handshake is about to complete, so every comparison is made in the cycle the result is due. Stalls are timed in the same way: the bench counts, one falling edge at a time, how long the input waits. It also samples `in_ready` at falling edges while an output is held.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

  typedef enum logic [1:0] {
    VERD_DROP = 2'd0,
    VERD_EXEC = 2'd1,
    VERD_JUMP = 2'd2
  } verdict_e;

endpackage

// File: rtl/cdf_classify.sv
module cdf_classify
  import cdf_pkg::*;
(
  input  logic     item_colour,
  input  logic     item_is_jump,
  input  logic     stage_colour,
  output verdict_e verdict
);

  logic colour_match;

  assign colour_match = (item_colour == stage_colour);

  always_comb begin
    if (!colour_match)
      verdict = VERD_DROP;
    else if (item_is_jump)
      verdict = VERD_JUMP;
    else
      verdict = VERD_EXEC;
  end

endmodule

// File: rtl/cdf_redirect_slot.sv
module cdf_redirect_slot #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_target,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_target,
  output logic              out_colour,
  output logic              stage_colour
);

  logic fire;

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_target   <= '0;
      out_colour   <= 1'b0;
      stage_colour <= 1'b0;
    end else begin
      if (fire) begin
        out_valid    <= 1'b0;
        stage_colour <= ~stage_colour;
      end
      if (load) begin
        out_valid  <= 1'b1;
        out_target <= load_target;
        out_colour <= ~stage_colour;
      end
    end
  end

endmodule

// File: rtl/cdf_exec_slot.sv
module cdf_exec_slot #(
  parameter int ADDR_W  = 16,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [ADDR_W-1:0]  load_addr,
  input  logic [INSTR_W-1:0] load_instr,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [INSTR_W-1:0] out_instr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_instr <= '0;
    end else begin
      if (out_valid && out_ready)
        out_valid <= 1'b0;
      if (load) begin
        out_valid <= 1'b1;
        out_addr  <= load_addr;
        out_instr <= load_instr;
      end
    end
  end

endmodule

// File: rtl/colour_decode_filter.sv
module colour_decode_filter
  import cdf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INSTR_W = 32,
  parameter int TGT_LSB = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic               in_colour,
  input  logic               in_is_jump,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [ADDR_W-1:0]  rd_target,
  output logic               rd_colour,
  output logic               ex_valid,
  input  logic               ex_ready,
  output logic [ADDR_W-1:0]  ex_addr,
  output logic [INSTR_W-1:0] ex_instr
);

  localparam int TGT_MSB = TGT_LSB + ADDR_W - 1;

  logic              stage_colour;
  logic              accept;
  verdict_e          verdict;
  logic [ADDR_W-1:0] jump_target;

  assign jump_target = in_instr[TGT_MSB:TGT_LSB];
  assign in_ready    = !rd_valid && (!ex_valid || ex_ready);
  assign accept      = in_valid && in_ready;

  cdf_classify u_classify (
    .item_colour  (in_colour),
    .item_is_jump (in_is_jump),
    .stage_colour (stage_colour),
    .verdict      (verdict)
  );

  cdf_redirect_slot #(.ADDR_W(ADDR_W)) u_redirect (
    .clk          (clk),
    .rst          (rst),
    .load         (accept && (verdict == VERD_JUMP)),
    .load_target  (jump_target),
    .out_ready    (rd_ready),
    .out_valid    (rd_valid),
    .out_target   (rd_target),
    .out_colour   (rd_colour),
    .stage_colour (stage_colour)
  );

  cdf_exec_slot #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_exec (
    .clk        (clk),
    .rst        (rst),
    .load       (accept && (verdict == VERD_EXEC)),
    .load_addr  (in_addr),
    .load_instr (in_instr),
    .out_ready  (ex_ready),
    .out_valid  (ex_valid),
    .out_addr   (ex_addr),
    .out_instr  (ex_instr)
  );

endmodule

// File: rtl/colour_decode_filter_chk.sv
module colour_decode_filter_chk #(
  parameter int ADDR_W  = 16,
  parameter int INSTR_W = 32,
  parameter int TGT_LSB = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [INSTR_W-1:0] in_instr,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic [ADDR_W-1:0]  rd_target,
  input logic               rd_colour,
  input logic               ex_valid,
  input logic               ex_ready,
  input logic [ADDR_W-1:0]  ex_addr,
  input logic [INSTR_W-1:0] ex_instr
);

  logic              ref_colour;
  logic [ADDR_W-1:0] last_target;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_colour  <= 1'b0;
      last_target <= '0;
    end else begin
      if (rd_valid && rd_ready)
        ref_colour <= ~ref_colour;
      if (in_valid && in_ready)
        last_target <= in_instr[TGT_LSB +: ADDR_W];
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_valid && !ex_valid && in_ready));

  // R2
  rd_target_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> (rd_target == last_target));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_target) && $stable(rd_colour)));

  // R3
  rd_colour_alt_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_colour != ref_colour));

  // R4
  single_output_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && ex_valid));

  // R6
  rd_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !in_ready);

  // R7
  ex_stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !ex_ready) |-> !in_ready);

  // R7
  ex_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !ex_ready) |=> (ex_valid && $stable(ex_addr) && $stable(ex_instr)));

  // R8
  ex_drain_open_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_ready && !rd_valid) |-> in_ready);

endmodule

bind colour_decode_filter colour_decode_filter_chk #(
  .ADDR_W (ADDR_W),
  .INSTR_W(INSTR_W),
  .TGT_LSB(TGT_LSB)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_instr (in_instr),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_target(rd_target),
  .rd_colour(rd_colour),
  .ex_valid (ex_valid),
  .ex_ready (ex_ready),
  .ex_addr  (ex_addr),
  .ex_instr (ex_instr)
);

// File: tb/colour_decode_filter_tb.sv
module colour_decode_filter_tb;

  localparam int ADDR_W  = 16;
  localparam int INSTR_W = 32;
  localparam int TGT_LSB = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [ADDR_W-1:0]  in_addr = '0;
  logic [INSTR_W-1:0] in_instr = '0;
  logic               in_colour = 1'b0;
  logic               in_is_jump = 1'b0;
  logic               rd_valid;
  logic               rd_ready = 1'b1;
  logic [ADDR_W-1:0]  rd_target;
  logic               rd_colour;
  logic               ex_valid;
  logic               ex_ready = 1'b1;
  logic [ADDR_W-1:0]  ex_addr;
  logic [INSTR_W-1:0] ex_instr;

  colour_decode_filter #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .TGT_LSB(TGT_LSB)) u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_instr(in_instr),
    .in_colour(in_colour), .in_is_jump(in_is_jump),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_target(rd_target), .rd_colour(rd_colour),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_addr(ex_addr), .ex_instr(ex_instr)
  );

  always #4 clk = ~clk;

  typedef struct packed { logic [ADDR_W-1:0] t; logic c; } rd_exp_t;
  typedef struct packed { logic [ADDR_W-1:0] a; logic [INSTR_W-1:0] i; } ex_exp_t;

  rd_exp_t rd_q[$];
  ex_exp_t ex_q[$];
  int      checks = 0;
  int      errors = 0;
  logic    model_col = 1'b0;
  int      cycle = 0;
  bit      stall_on = 1'b0;
  logic    rd_fix = 1'b1;
  logic    ex_fix = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    if (stall_on) begin
      rd_ready = 1'($urandom_range(0, 1));
      ex_ready = 1'($urandom_range(0, 1));
    end else begin
      rd_ready = rd_fix;
      ex_ready = ex_fix;
    end
  end

  always @(negedge clk) begin
    cycle++;
    if (cycle > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycle, 100000);
      summary();
    end
    if (!rst) begin
      if (rd_valid && rd_ready) begin
        if (rd_q.size() == 0) begin
          check(1'b0, "R5", "unexpected redirect", longint'(rd_target), 0);
        end else begin
          rd_exp_t e;
          e = rd_q.pop_front();
          check(rd_target == e.t, "R2", "redirect target", longint'(rd_target), longint'(e.t));
          check(rd_colour == e.c, "R3", "redirect colour", longint'(rd_colour), longint'(e.c));
        end
      end
      if (ex_valid && ex_ready) begin
        if (ex_q.size() == 0) begin
          check(1'b0, "R5", "unexpected execute item", longint'(ex_addr), 0);
        end else begin
          ex_exp_t e;
          e = ex_q.pop_front();
          check(ex_addr == e.a, "R4", "execute address", longint'(ex_addr), longint'(e.a));
          check(ex_instr == e.i, "R4", "execute instr", longint'(ex_instr), longint'(e.i));
        end
      end
      if (rd_valid)
        check(!in_ready, "R6", "in_ready during redirect", longint'(in_ready), 0);
      if (ex_valid && !ex_ready && !rd_valid)
        check(!in_ready, "R7", "in_ready during execute stall", longint'(in_ready), 0);
      if (ex_valid && ex_ready && !rd_valid)
        check(in_ready, "R8", "in_ready while execute drains", longint'(in_ready), 1);
    end
  end

  // Called just after a rising edge; returns just after the accepting edge.
  task automatic send(input logic [ADDR_W-1:0] a, input logic col, input logic jmp,
                      input logic [INSTR_W-1:0] ins, output int waits);
    in_valid   = 1'b1;
    in_addr    = a;
    in_colour  = col;
    in_is_jump = jmp;
    in_instr   = ins;
    waits = 0;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      waits++;
    end
    if (col == model_col) begin
      if (jmp) begin
        rd_q.push_back('{t: ins[TGT_LSB +: ADDR_W], c: ~model_col});
        model_col = ~model_col;
      end else begin
        ex_q.push_back('{a: a, i: ins});
      end
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!rd_valid && !ex_valid && in_ready, "R1", "idle during reset",
          longint'({rd_valid, ex_valid, in_ready}), 1);
    @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    check(!rd_valid && !ex_valid && in_ready, "R1", "idle after reset",
          longint'({rd_valid, ex_valid, in_ready}), 1);
    @(posedge clk);
    #1;

    // R4: matching non-jump with colour 0 after reset
    send(16'h0100, 1'b0, 1'b0, 32'hA1B2C3D4, w);
    @(negedge clk);
    check(ex_valid == 1'b1, "R4", "ex_valid one edge after accept", longint'(ex_valid), 1);
    idle(2);

    // R5: mismatched items dropped, colour untouched
    send(16'h0104, 1'b1, 1'b0, 32'h11111111, w);
    send(16'h0108, 1'b1, 1'b1, 32'h22334422, w);
    @(negedge clk);
    check(!rd_valid && !ex_valid, "R5", "no output for stale items",
          longint'({rd_valid, ex_valid}), 0);
    @(posedge clk);
    #1;
    send(16'h010C, 1'b0, 1'b0, 32'h33333333, w);
    idle(2);

    // R2, R3: taken jump, then items judged against new colour
    send(16'h0110, 1'b0, 1'b1, 32'h00BEEF00, w);
    @(negedge clk);
    check(rd_valid == 1'b1, "R2", "rd_valid one edge after accept", longint'(rd_valid), 1);
    idle(2);
    send(16'h0114, 1'b0, 1'b0, 32'h44444444, w);
    send(16'hBEEF, 1'b1, 1'b0, 32'h55555555, w);
    idle(2);

    // R6: redirect held back by fetch side
    rd_fix = 1'b0;
    idle(1);
    send(16'hBEF0, 1'b1, 1'b1, 32'h00123400, w);
    repeat (5) @(negedge clk);
    check(rd_valid && !in_ready, "R6", "redirect still pending, input closed",
          longint'({rd_valid, in_ready}), 2);
    rd_fix = 1'b1;
    idle(3);
    send(16'h1234, 1'b0, 1'b1, 32'h00567800, w);
    idle(3);

    // R8: back-to-back matching non-jumps, colour now 1
    for (int k = 0; k < 4; k++) begin
      send(16'h5678 + 16'(4 * k), 1'b1, 1'b0, 32'hC0DE0000 + k, w);
      if (k > 0)
        check(w == 0, "R8", "wait cycles in a stream", longint'(w), 0);
    end
    idle(2);

    // R7: execute side stalls
    ex_fix = 1'b0;
    idle(1);
    send(16'h6000, 1'b1, 1'b0, 32'h66666666, w);
    fork
      begin
        repeat (4) @(posedge clk);
        #1;
        ex_fix = 1'b1;
      end
    join_none
    send(16'h6004, 1'b1, 1'b0, 32'h77777777, w);
    check(w >= 3, "R7", "input held during execute stall", longint'(w), 3);
    idle(3);

    // Mixed traffic with random back-pressure
    stall_on = 1'b1;
    for (int k = 0; k < 60; k++) begin
      logic col;
      logic jmp;
      col = ($urandom_range(0, 3) == 0) ? ~model_col : model_col;
      jmp = ($urandom_range(0, 4) == 0);
      send(16'(k * 4), col, jmp, $urandom(), w);
    end
    stall_on = 1'b0;
    rd_fix = 1'b1;
    ex_fix = 1'b1;
    idle(6);
    check(rd_q.size() == 0, "R2", "redirects left over", longint'(rd_q.size()), 0);
    check(ex_q.size() == 0, "R4", "execute items left over", longint'(ex_q.size()), 0);
    summary();
  end

endmodule